// File: doc/BRIEF.md
# Memory-Fed Sample Averager

This block computes the integer mean of a fixed-size group of signed samples that sit in an external single-port RAM. A one-cycle start pulse, taken while the block is idle, launches one transaction. The block then walks the RAM from the lowest address upward, one read per cycle, with an active-high chip enable. It sign-extends each returned word and sums it into a wider accumulator.

Once the last word has arrived, the block divides the sum by the sample count. The division truncates toward zero, the way C integer division does. The quotient is loaded into a result register and a one-cycle done pulse marks it valid. The result then stays on the port until the next transaction completes. Only one transaction runs at a time, and the idle output tells the surrounding logic when a new start will be accepted.

The RAM samples the address on a clock edge when chip enable is high and drives the word for it during the following cycle. The block adds that word at the end of that cycle, so every addition happens one cycle after its address.

Top module: `mem_sample_avg`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, idle is 1, done is 0, memCe is 0 and result is 0. Reset is active high and synchronous.
- R2: A start pulse sampled while idle is 1 drives idle to 0 in the next cycle. A start that arrives while a transaction is running is ignored: the running transaction still makes exactly 8 reads, produces one done pulse and returns the same quotient.
- R3: In the 8 cycles right after the start cycle, memCe is 1 and memAddr steps through 0,1,...,7 in increasing order, one address per cycle. memCe is 0 in every other cycle and is never 1 while idle is 1.
- R4: The word on memRdData in the cycle after an address cycle belongs to that address. It is read as a 6-bit two's-complement value and added into a 9-bit signed sum.
- R5: result is the 9-bit two's-complement value of the sum of the 8 samples divided by 8, truncated toward zero. For example, the samples 12,10,-12,23,4,5,10,-10 give 5, and a sum of -9 gives -1.
- R6: done is 1 for exactly one cycle, the 11th cycle after the cycle in which start was sampled. idle is 1 in that cycle.
- R7: result keeps its value in every cycle until the next done pulse.
- R8: Every returned quotient lies within the range of one sample, -32 to 31. The sum never leaves the 9-bit signed range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches a transaction when idle |
| idle | output | 1 | High when no transaction is running |
| done | output | 1 | One-cycle pulse that marks result as valid |
| result | output | 9 | Signed quotient, held until the next completion |
| memAddr | output | 3 | Read address to the external RAM |
| memCe | output | 1 | Active-high RAM chip enable |
| memRdData | input | 6 | Signed word returned by the RAM one cycle after its address |

## Verification
A word counter that is off by one shows up at once on memAddr, and as an address sequence that starts in the wrong place or does not contain exactly eight reads. A wrong state transition moves done away from the 11th cycle, and the bench measures that latency in cycles for every transaction. If the accumulator drops a word, catches a stale one or gets the sign extension wrong, the result is wrong at the very next done. The sweeps of constant samples and mixed patterns cover both signs and both ends of the range. A rounding mistake in the division only appears for negative sums that are not multiples of eight, and the mixed patterns and the dedicated cases produce many of those.

// File: rtl/avg_pkg.sv
package avg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_DRAIN,
    ST_FINISH
  } avgState_t;

  typedef struct packed {
    logic clrAcc;
    logic accEn;
    logic loadResult;
  } avgStrobe_t;

endpackage

// File: rtl/avg_ctrl.sv
module avg_ctrl
  import avg_pkg::*;
#(
  parameter int NUM_SAMPLES = 8,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output avgStrobe_t        strobes,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe,
  output logic              idle,
  output logic              done
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_SAMPLES - 1);

  avgState_t         state;
  logic [ADDR_W-1:0] wordCnt;
  logic              wordValidQ;
  logic              doneQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      wordCnt    <= '0;
      wordValidQ <= 1'b0;
      doneQ      <= 1'b0;
    end else begin
      wordValidQ <= (state == ST_READ);
      doneQ      <= (state == ST_FINISH);
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_READ;
            wordCnt <= '0;
          end
        end
        ST_READ: begin
          if (wordCnt == LAST_ADDR) begin
            state <= ST_DRAIN;
          end else begin
            wordCnt <= wordCnt + 1'b1;
          end
        end
        ST_DRAIN:  state <= ST_FINISH;
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    idle               = (state == ST_IDLE);
    memCe              = (state == ST_READ);
    memAddr            = wordCnt;
    done               = doneQ;
    strobes.clrAcc     = idle && start;
    strobes.accEn      = wordValidQ;
    strobes.loadResult = (state == ST_FINISH);
  end

endmodule

// File: rtl/avg_datapath.sv
module avg_datapath
  import avg_pkg::*;
#(
  parameter int NUM_SAMPLES = 8,
  parameter int SAMPLE_W    = 6,
  parameter int ACC_W       = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  avgStrobe_t          strobes,
  input  logic [SAMPLE_W-1:0] rdData,
  output logic [ACC_W-1:0]    result
);

  localparam int  SHIFT   = $clog2(NUM_SAMPLES);
  localparam bit  IS_POW2 = (NUM_SAMPLES & (NUM_SAMPLES - 1)) == 0;

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] rdExt;
  logic signed [ACC_W-1:0] quotient;
  logic        [ACC_W-1:0] resultQ;

  assign rdExt = {{(ACC_W - SAMPLE_W){rdData[SAMPLE_W-1]}}, rdData};

  generate
    if (IS_POW2) begin : g_shiftDiv
      localparam logic signed [ACC_W-1:0] BIAS = ACC_W'(NUM_SAMPLES - 1);
      logic signed [ACC_W-1:0] biased;
      always_comb begin
        biased   = acc[ACC_W-1] ? (acc + BIAS) : acc;
        quotient = biased >>> SHIFT;
      end
    end else begin : g_fullDiv
      localparam logic signed [ACC_W:0] DIVISOR = (ACC_W + 1)'(NUM_SAMPLES);
      logic signed [ACC_W:0] wideAcc;
      logic signed [ACC_W:0] wideQ;
      always_comb begin
        wideAcc  = {acc[ACC_W-1], acc};
        wideQ    = wideAcc / DIVISOR;
        quotient = wideQ[ACC_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      resultQ <= '0;
    end else begin
      if (strobes.clrAcc) begin
        acc <= '0;
      end else if (strobes.accEn) begin
        acc <= acc + rdExt;
      end
      if (strobes.loadResult) begin
        resultQ <= quotient;
      end
    end
  end

  assign result = resultQ;

endmodule

// File: rtl/mem_sample_avg.sv
module mem_sample_avg
  import avg_pkg::*;
#(
  parameter int NUM_SAMPLES = 8,
  parameter int SAMPLE_W    = 6,
  parameter int ACC_W       = 9,
  parameter int ADDR_W      = $clog2(NUM_SAMPLES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  output logic                idle,
  output logic                done,
  output logic [ACC_W-1:0]    result,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memCe,
  input  logic [SAMPLE_W-1:0] memRdData
);

  avgStrobe_t strobes;

  avg_ctrl #(
    .NUM_SAMPLES(NUM_SAMPLES),
    .ADDR_W     (ADDR_W)
  ) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .strobes(strobes),
    .memAddr(memAddr),
    .memCe  (memCe),
    .idle   (idle),
    .done   (done)
  );

  avg_datapath #(
    .NUM_SAMPLES(NUM_SAMPLES),
    .SAMPLE_W   (SAMPLE_W),
    .ACC_W      (ACC_W)
  ) dp_i (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .rdData (memRdData),
    .result (result)
  );

endmodule

// File: rtl/avg_checker.sv
module avg_checker #(
  parameter int NUM_SAMPLES = 8,
  parameter int SAMPLE_W    = 6,
  parameter int ACC_W       = 9,
  parameter int ADDR_W      = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              idle,
  input logic              done,
  input logic [ACC_W-1:0]  result,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCe
);

  localparam int MIN_VAL = -(2 ** (SAMPLE_W - 1));
  localparam int MAX_VAL = (2 ** (SAMPLE_W - 1)) - 1;

  assert_start_leaves_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (start && idle) |=> (!idle && memCe && memAddr == '0));

  assert_ce_only_busy_R3: assert property (@(posedge clk) disable iff (rst)
    memCe |-> !idle);

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (memCe && $past(memCe)) |-> (memAddr == ADDR_W'($past(memAddr) + 1'b1)));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (idle && !memCe));

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !done |=> (done || $stable(result)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> ($signed(result) >= MIN_VAL && $signed(result) <= MAX_VAL));

endmodule

bind mem_sample_avg avg_checker #(
  .NUM_SAMPLES(NUM_SAMPLES),
  .SAMPLE_W   (SAMPLE_W),
  .ACC_W      (ACC_W),
  .ADDR_W     (ADDR_W)
) chk_i (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .idle   (idle),
  .done   (done),
  .result (result),
  .memAddr(memAddr),
  .memCe  (memCe)
);

// File: tb/mem_sample_avg_tb.sv
module mem_sample_avg_tb_top;

  localparam int N  = 8;
  localparam int SW = 6;
  localparam int AW = 9;
  localparam int XW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          idle, done, memCe;
  logic [AW-1:0] result;
  logic [XW-1:0] memAddr;
  logic [SW-1:0] memRdData = '0;

  logic [SW-1:0] memArr [N];

  int checks = 0;
  int failures = 0;
  int cycleCnt = 0;
  int ceCount = 0;
  int addrErr = 0;
  int doneCount = 0;

  always #10ns clk = ~clk;

  mem_sample_avg dut_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .idle     (idle),
    .done     (done),
    .result   (result),
    .memAddr  (memAddr),
    .memCe    (memCe),
    .memRdData(memRdData)
  );

  // RAM model: address captured on the edge with chip enable, data the cycle after
  always @(posedge clk) begin
    if (memCe) memRdData <= memArr[memAddr];
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (memCe) begin
        if (int'(memAddr) != ceCount) addrErr++;
        ceCount++;
      end
      if (done) doneCount++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expMean(input int s[N]);
    int sum = 0;
    for (int k = 0; k < N; k++) sum += s[k];
    return (sum < 0) ? -((-sum) / N) : (sum / N);
  endfunction

  task automatic runTxn(input int s[N], input bit busyStart);
    int lat;
    int exp;
    int held;
    for (int k = 0; k < N; k++) memArr[k] = SW'(s[k]);
    exp = expMean(s);
    ceCount = 0;
    addrErr = 0;
    doneCount = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    check(!idle, "R2 idle low after start", int'(idle), 0);
    check(memCe && memAddr == '0, "R3 first read right after start", int'(memAddr), 0);
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
      if (busyStart && lat == 4) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    check(lat == 11, "R6 done latency", lat, 11);
    check(idle, "R6 idle with done", int'(idle), 1);
    check($signed(result) == exp, "R5 R4 quotient", int'($signed(result)), exp);
    check(ceCount == N, "R3 read count", ceCount, N);
    check(addrErr == 0, "R3 address order", addrErr, 0);
    held = int'($signed(result));
    @(negedge clk);
    check(!done, "R6 done one cycle", int'(done), 0);
    @(negedge clk);
    check(int'($signed(result)) == held, "R7 result held", int'($signed(result)), held);
    check(!memCe, "R3 no read when idle", int'(memCe), 0);
    if (busyStart)
      check(doneCount == 1, "R2 busy start ignored", doneCount, 1);
  endtask

  initial begin
    int s[N];
    repeat (3) @(negedge clk);
    check(idle && !done && !memCe && result == '0, "R1 reset state during reset",
          int'(result), 0);
    rst = 1'b0;
    @(negedge clk);
    check(idle && !done && !memCe && result == '0, "R1 reset state after release",
          int'({idle, done, memCe}), 4);

    s = '{12, 10, -12, 23, 4, 5, 10, -10};
    runTxn(s, 1'b0);
    check($signed(result) == 5, "R5 worked example", int'($signed(result)), 5);

    s = '{31, 31, 31, 31, 31, 31, 31, 31};
    runTxn(s, 1'b0);
    s = '{-32, -32, -32, -32, -32, -32, -32, -32};
    runTxn(s, 1'b0);
    check($signed(result) == -32, "R8 most negative sum", int'($signed(result)), -32);
    s = '{-1, 0, 0, 0, 0, 0, 0, 0};
    runTxn(s, 1'b0);
    check(result == '0, "R5 small negative truncates to zero", int'($signed(result)), 0);
    s = '{-9, 0, 0, 0, 0, 0, 0, 0};
    runTxn(s, 1'b0);
    check($signed(result) == -1, "R5 sum -9", int'($signed(result)), -1);
    s = '{9, 0, 0, 0, 0, 0, 0, 0};
    runTxn(s, 1'b0);

    s = '{12, 10, -12, 23, 4, 5, 10, -10};
    runTxn(s, 1'b1);

    for (int v = -32; v < 32; v++) begin
      for (int k = 0; k < N; k++) s[k] = v;
      runTxn(s, 1'b0);
    end
    for (int seed = 0; seed < 64; seed++) begin
      for (int k = 0; k < N; k++) s[k] = ((seed * 7 + k * 13 + seed * k * 5) % 64) - 32;
      runTxn(s, (seed % 9) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 100000) begin
      failures++;
      checks++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", cycleCnt, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule